// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Thresholds

This block is a 64-word by 36-bit FIFO that connects two unrelated clock domains. A producer writes on the write clock and a consumer reads on the read clock. The write side reports a full flag and an almost-full flag. The read side reports an empty flag and an almost-empty flag. All four flags are active low. A read moves the oldest stored word into a registered output word, and that word stays unchanged until the next accepted read.

Each port accepts a transfer only when four qualifiers line up: chip select (active low), the direction select, the port enable, and a mailbox select that must be low. A single offset X is captured from a two-bit code while reset is held. It sets both almost thresholds, one counted from the empty end and one from the full end. Pointers cross between the domains as Gray codes.

A flag sees a change made by its own side on the same edge. It sees a change made by the other side on the second rising edge of its own clock. The user relies on this fixed latency when setting burst sizes against the almost flags.

Top module: `dual_clock_thr_fifo`

## Requirements
- R1: While `rst_n` is sampled low, `full_n`=0, `empty_n`=0, `aempty_n`=0 and `afull_n`=1. Both pointers return to zero.
- R2: After `rst_n` is sampled high, `full_n` stays 0 after the first write-clock edge and rises on the second write-clock edge.
- R3: The offset X is taken from `thr_sel` at reset release and holds until the next reset. The codes map as follows: 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 12, 2'b11 gives 16.
- R4: A word is stored on a write-clock edge only when all of these hold: `a_cs_n`=0, `a_dir_wr`=1, `a_en`=1, `a_mbx`=0 and `full_n`=1. On any other edge, nothing is stored and the write pointer does not move.
- R5: A read happens on a read-clock edge only when all of these hold: `b_cs_n`=0, `b_dir_wr`=0, `b_en`=1, `b_mbx`=0 and `empty_n`=1. A read loads the oldest word into `rdata`. On any other edge, `rdata` holds its value.
- R6: With N the occupancy as seen by a flag's own domain, the flags are: `empty_n`=0 only when N=0; `aempty_n`=0 when N ≤ X; `afull_n`=0 when N ≥ 64−X; `full_n`=0 only when N=64.
- R7: A write shows on `empty_n` and `aempty_n` on the second read-clock edge after the write. A read shows on `full_n` and `afull_n` on the second write-clock edge after the read. A written word can therefore be read no sooner than the third read-clock edge.
- R8: A write that makes the FIFO full clears `full_n` on that same edge. A read that takes the last visible word clears `empty_n` on that same edge.
- R9: Words leave in the order they were accepted, with no loss or duplication, when the two clocks run at unrelated periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled by both clocks |
| thr_sel | input | 2 | Code for the almost-threshold offset, captured while in reset |
| a_cs_n | input | 1 | Write-port chip select, active low |
| a_dir_wr | input | 1 | Write-port direction, 1 selects a write |
| a_en | input | 1 | Write-port enable |
| a_mbx | input | 1 | Write-port mailbox select, must be 0 for a FIFO write |
| wdata | input | 36 | Word to store |
| full_n | output | 1 | Low when full (write domain) |
| afull_n | output | 1 | Low when almost full (write domain) |
| b_cs_n | input | 1 | Read-port chip select, active low |
| b_dir_wr | input | 1 | Read-port direction, 0 selects a read |
| b_en | input | 1 | Read-port enable |
| b_mbx | input | 1 | Read-port mailbox select, must be 0 for a FIFO read |
| rdata | output | 36 | Registered output word |
| empty_n | output | 1 | Low when empty (read domain) |
| aempty_n | output | 1 | Low when almost empty (read domain) |

## Verification
The case that needs the most care is a write in one domain and a read in the other falling in the same interval. This matters most when the FIFO sits at a flag boundary, so that each side's flag has to show its own action at once while showing the other side's action two edges late. The bench provokes this with phases that mostly fill, mostly drain, and balance the traffic, and with clocks whose edges never coincide. A model tracks, for each domain, which of the opposite side's operations its flags may already reflect. Every flag is compared with that model on every cycle, and every word read is compared with a reference queue.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Offset X selected by a two-bit code: step * (code + 1)
  function automatic int unsigned thr_offset(input logic [1:0] code, input int unsigned step);
    return step * (int'(code) + 1);
  endfunction

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int W  = 36,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // the read register is the FIFO output word
  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 7,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int AW   = 6,
  parameter int STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  thr_sel,
  input  logic        req,
  input  logic [AW:0] rgray_s,
  output logic        do_wr,
  output logic [AW-1:0] waddr,
  output logic [AW:0] wgray,
  output logic        full_n,
  output logic        afull_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wptr, wptr_nx, rptr_b, level_nx, thr;
  logic          rdy;

  assign do_wr    = req && full_n;
  assign wptr_nx  = wptr + PW'(do_wr);
  assign rptr_b   = PW'(gray_to_bin(32'(rgray_s)));
  assign level_nx = wptr_nx - rptr_b;
  assign waddr    = wptr[AW-1:0];

  // flag registers act as the second synchronizer stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      wgray   <= '0;
      rdy     <= 1'b0;
      full_n  <= 1'b0;
      afull_n <= 1'b1;
      thr     <= PW'(thr_offset(thr_sel, STEP));
    end else begin
      wptr    <= wptr_nx;
      wgray   <= PW'(bin_to_gray(32'(wptr_nx)));
      rdy     <= 1'b1;
      full_n  <= rdy && (level_nx != PW'(DEPTH));
      afull_n <= level_nx < (PW'(DEPTH) - thr);
    end
  end

  // R4
  no_wr_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |=> wptr == $past(wptr));
  // R2
  full_late_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |=> !full_n);
  // R8
  full_on_last_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && (wptr - rptr_b) == PW'(DEPTH - 1)) |=> !full_n);
  // R6
  wr_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr - rptr_b) <= PW'(DEPTH));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int AW   = 6,
  parameter int STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  thr_sel,
  input  logic        req,
  input  logic [AW:0] wgray_s,
  output logic        do_rd,
  output logic [AW-1:0] raddr,
  output logic [AW:0] rgray,
  output logic        empty_n,
  output logic        aempty_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rptr, rptr_nx, wptr_b, level_nx, thr;

  assign do_rd    = req && empty_n;
  assign rptr_nx  = rptr + PW'(do_rd);
  assign wptr_b   = PW'(gray_to_bin(32'(wgray_s)));
  assign level_nx = wptr_b - rptr_nx;
  assign raddr    = rptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr     <= '0;
      rgray    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
      thr      <= PW'(thr_offset(thr_sel, STEP));
    end else begin
      rptr     <= rptr_nx;
      rgray    <= PW'(bin_to_gray(32'(rptr_nx)));
      empty_n  <= level_nx != '0;
      aempty_n <= level_nx > thr;
    end
  end

  // R5
  no_rd_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |=> rptr == $past(rptr));
  // R8
  empty_on_last_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && (wptr_b - rptr) == PW'(1)) |=> !empty_n);
  // R6
  rd_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr_b - rptr) <= PW'(DEPTH));
endmodule

// File: rtl/dual_clock_thr_fifo.sv
module dual_clock_thr_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 64,
  parameter int STEP  = 4
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst_n,
  input  logic [1:0]   thr_sel,
  input  logic         a_cs_n,
  input  logic         a_dir_wr,
  input  logic         a_en,
  input  logic         a_mbx,
  input  logic [W-1:0] wdata,
  output logic         full_n,
  output logic         afull_n,
  input  logic         b_cs_n,
  input  logic         b_dir_wr,
  input  logic         b_en,
  input  logic         b_mbx,
  output logic [W-1:0] rdata,
  output logic         empty_n,
  output logic         aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  // one flop here plus the flag register forms the two-stage crossing
  localparam int SYNC_STAGES = 1;

  logic          wr_req, rd_req, do_wr, do_rd;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;

  assign wr_req = !a_cs_n &&  a_dir_wr && a_en && !a_mbx;
  assign rd_req = !b_cs_n && !b_dir_wr && b_en && !b_mbx;

  dcf_wr_ctl #(.AW(AW), .STEP(STEP)) u_wr (
    .clk(wclk), .rst_n(rst_n), .thr_sel(thr_sel), .req(wr_req),
    .rgray_s(rgray_s), .do_wr(do_wr), .waddr(waddr), .wgray(wgray),
    .full_n(full_n), .afull_n(afull_n));

  dcf_rd_ctl #(.AW(AW), .STEP(STEP)) u_rd (
    .clk(rclk), .rst_n(rst_n), .thr_sel(thr_sel), .req(rd_req),
    .wgray_s(wgray_s), .do_rd(do_rd), .raddr(raddr), .rgray(rgray),
    .empty_n(empty_n), .aempty_n(aempty_n));

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));

  dcf_ram #(.W(W), .AW(AW)) u_ram (
    .wclk(wclk), .we(do_wr), .waddr(waddr), .wdata(wdata),
    .rclk(rclk), .re(do_rd), .raddr(raddr), .rdata(rdata));
endmodule

// File: tb/test_dual_clock_thr_fifo.sv
`timescale 1ps/1ps
module test_dual_clock_thr_fifo;
  localparam int W = 36;
  localparam int DEPTH = 64;
  localparam int WCLK_PERIOD = 10000;
  localparam int RCLK_PERIOD = 13000;
  localparam int RCLK_PHASE  = 1700;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic [1:0] thr_sel = 2'b00;
  logic a_cs_n = 1, a_dir_wr = 0, a_en = 0, a_mbx = 0;
  logic b_cs_n = 1, b_dir_wr = 1, b_en = 0, b_mbx = 0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic full_n, afull_n, empty_n, aempty_n;

  int n_tests = 0, n_fail = 0;
  int wr_commits = 0, rd_commits = 0;
  int r_cap = 0, r_vis = 0, w_cap = 0, w_vis = 0, w_age = 0;
  int w_thr = 4, r_thr = 4;
  logic [W-1:0] refq [$];
  logic [W-1:0] last_exp;
  bit have_exp = 0;

  dual_clock_thr_fifo #(.W(W), .DEPTH(DEPTH)) i_dual_clock_thr_fifo (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .thr_sel(thr_sel),
    .a_cs_n(a_cs_n), .a_dir_wr(a_dir_wr), .a_en(a_en), .a_mbx(a_mbx),
    .wdata(wdata), .full_n(full_n), .afull_n(afull_n),
    .b_cs_n(b_cs_n), .b_dir_wr(b_dir_wr), .b_en(b_en), .b_mbx(b_mbx),
    .rdata(rdata), .empty_n(empty_n), .aempty_n(aempty_n));

  always #(WCLK_PERIOD/2) wclk = ~wclk;
  initial begin
    #RCLK_PHASE;
    forever begin rclk = ~rclk; #(RCLK_PERIOD/2); end
  end

  function automatic int exp_thr(input logic [1:0] s);
    case (s)
      2'b00: return 4;
      2'b01: return 8;
      2'b10: return 12;
      default: return 16;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-domain visibility of the opposite side's operations (two-edge latency)
  always @(posedge wclk) begin
    if (!rst_n) begin
      r_cap <= 0; r_vis <= 0; w_age <= 0; w_thr <= exp_thr(thr_sel);
    end else begin
      r_cap <= rd_commits; r_vis <= r_cap;
      if (w_age < 2) w_age <= w_age + 1;
    end
  end
  always @(posedge rclk) begin
    if (!rst_n) begin
      w_cap <= 0; w_vis <= 0; r_thr <= exp_thr(thr_sel);
    end else begin
      w_cap <= wr_commits; w_vis <= w_cap;
    end
  end

  always @(negedge wclk) begin
    if (rst_n) begin
      int cnt;
      bit ef;
      cnt = wr_commits - r_vis;
      ef  = (w_age >= 2) && (cnt != DEPTH);
      // R2 R6 R7 R8
      chk(full_n == ef, (w_age < 2) ? "R2 full_n after reset" : "R6 R7 R8 full_n",
          64'(full_n), 64'(ef));
      // R3 R6 R7
      chk(afull_n == (cnt < DEPTH - w_thr), "R3 R6 R7 afull_n",
          64'(afull_n), 64'(cnt < DEPTH - w_thr));
    end
  end

  always @(negedge rclk) begin
    if (rst_n) begin
      int cnt;
      cnt = w_vis - rd_commits;
      // R6 R7 R8
      chk(empty_n == (cnt != 0), "R6 R7 R8 empty_n", 64'(empty_n), 64'(cnt != 0));
      // R3 R6 R7
      chk(aempty_n == (cnt > r_thr), "R3 R6 R7 aempty_n", 64'(aempty_n), 64'(cnt > r_thr));
    end
  end

  task automatic do_reset(input logic [1:0] sel);
    @(negedge wclk);
    a_cs_n = 1; b_cs_n = 1;
    thr_sel = sel;
    rst_n = 0;
    wr_commits = 0; rd_commits = 0;
    refq.delete();
    have_exp = 0;
    repeat (6) @(posedge rclk);
    repeat (2) @(posedge wclk);
    @(negedge wclk);
    // R1
    chk(full_n == 1'b0,   "R1 full_n in reset",   64'(full_n), 64'(0));
    chk(afull_n == 1'b1,  "R1 afull_n in reset",  64'(afull_n), 64'(1));
    chk(empty_n == 1'b0,  "R1 empty_n in reset",  64'(empty_n), 64'(0));
    chk(aempty_n == 1'b0, "R1 aempty_n in reset", 64'(aempty_n), 64'(0));
    rst_n = 1;
  endtask

  // R4: writes, with some attempts spoiled by one wrong qualifier
  task automatic wr_phase(input int cycles, input int pct);
    for (int i = 0; i < cycles; i++) begin
      bit want, spoil, will;
      @(negedge wclk);
      want  = ($urandom % 100) < pct;
      spoil = ($urandom % 4) == 0;
      a_cs_n = 0; a_dir_wr = 1; a_en = want; a_mbx = 0;
      if (spoil) begin
        case ($urandom % 4)
          0: a_cs_n = 1;
          1: a_dir_wr = 0;
          2: a_en = 0;
          default: a_mbx = 1;
        endcase
      end
      wdata = {$urandom, $urandom} & {W{1'b1}};
      will = want && !spoil && full_n;
      if (will) refq.push_back(wdata);
      @(posedge wclk);
      if (will) wr_commits++;
    end
    @(negedge wclk);
    a_en = 0;
  endtask

  // R5 R9: reads checked against the reference queue; idle edges must hold rdata
  task automatic rd_phase(input int cycles, input int pct);
    bit prev = 0;
    for (int i = 0; i <= cycles; i++) begin
      bit want, spoil, will;
      @(negedge rclk);
      if (have_exp) begin
        if (prev) chk(rdata == last_exp, "R4 R5 R9 read data", 64'(rdata), 64'(last_exp));
        else      chk(rdata == last_exp, "R5 rdata hold", 64'(rdata), 64'(last_exp));
      end
      if (i == cycles) break;
      want  = ($urandom % 100) < pct;
      spoil = ($urandom % 4) == 0;
      b_cs_n = 0; b_dir_wr = 0; b_en = want; b_mbx = 0;
      if (spoil) begin
        case ($urandom % 4)
          0: b_cs_n = 1;
          1: b_dir_wr = 1;
          2: b_en = 0;
          default: b_mbx = 1;
        endcase
      end
      will = want && !spoil && empty_n;
      @(posedge rclk);
      prev = will;
      if (will) begin
        rd_commits++;
        if (refq.size() == 0) begin
          chk(1'b0, "R5 R9 read with empty reference", 64'(0), 64'(1));
          prev = 0;
        end else begin
          last_exp = refq.pop_front();
          have_exp = 1;
        end
      end
    end
    b_en = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      fork wr_phase(300, 90); rd_phase(200, 10); join
      fork wr_phase(250, 5);  rd_phase(250, 95); join
      fork wr_phase(300, 50); rd_phase(230, 60); join
      fork wr_phase(20, 0);   rd_phase(150, 100); join
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(WCLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule